// File: doc/BRIEF.md
# Wide Unsigned Divider with Remainder

This block divides a double-width unsigned dividend by a single-width unsigned divisor. It returns the quotient and the remainder together. The dividend is built from two operands. `op_a` supplies the upper word and `op_c` supplies the lower word. `op_b` is the divisor. One pulse on `start` launches an operation. The block reports completion with a single-cycle `done` pulse, and the results stay on its outputs until the next accepted start.

Before any iteration begins, the block tests whether the quotient can fit in one word. When the divisor is zero, or the upper dividend word is not below the divisor, the operation is an overflow. An overflow finishes on the following cycle with fixed results: the quotient is all ones, the remainder is zero, and the overflow flag is set. Every other operation runs a radix-2 restoring loop. The loop makes one pass for each bit of the word width, and the lower dividend word is shifted out as quotient bits are shifted in.

Top module: `divrem_wide`

## Requirements
- R1: For a non-overflow operation, the quotient and remainder satisfy `quot * op_b + rem == {op_a, op_c}` and `rem < op_b`, with all values unsigned.
- R2: An operation is an overflow when `op_b` is zero or `op_a >= op_b`. Its results are `quot` all ones, `rem` zero and `ovf` equal to 1.
- R3: An overflow operation does not raise `busy`. Its `done` pulse comes at the first rising edge after the start edge.
- R4: A non-overflow operation holds `busy` at 1 from the edge after the start edge. `done` rises W edges after that first edge, so it appears W+1 edges after the start edge.
- R5: `done` is high for exactly one cycle, and `busy` is 0 whenever `done` is 1.
- R6: While the block is idle with no start, `quot`, `rem` and `ovf` keep their values.
- R7: A `start` sampled while `busy` is 1 is ignored, and the running operation finishes with the results of its original operands.
- R8: After reset, `busy`, `done`, `ovf`, `quot` and `rem` are all 0.
- R9: A non-overflow operation ends with `ovf` equal to 0, even when the operation before it overflowed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch an operation when idle |
| op_a | input | W | Upper word of dividend |
| op_b | input | W | Divisor |
| op_c | input | W | Lower word of dividend |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle completion pulse |
| quot | output | W | Quotient, low word |
| rem | output | W | Remainder, low word |
| ovf | output | 1 | Overflow flag |

## Verification
The bench uses an 8-bit configuration so that every divisor value can be swept. For each divisor it pairs upper words of 0, 1, half the divisor, the divisor minus one, the divisor itself and all ones with several lower words. These cases cover both sides of the overflow boundary and include the largest quotients that still fit. A zero divisor and a divisor of one separate the two overflow causes from the degenerate identity division. Overflow operations placed next to valid ones show that the flag clears again. A start issued in the middle of a division, and idle waits after `done`, show that the block ignores the extra start and that its outputs hold.

// File: rtl/divrem_wide.sv
module divrem_wide #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic         ovf
);
  localparam int CW = $clog2(W + 1);

  logic         busy_r, done_r, ovf_r;
  logic [W-1:0] rem_r, q_r, b_r;
  logic [CW-1:0] cnt_r;

  wire          accept = start && !busy_r;
  wire          bad    = (op_b == '0) || (op_a >= op_b);
  wire  [W:0]   trial  = {rem_r, q_r[W-1]};
  wire  [W:0]   diff   = trial - {1'b0, b_r};
  wire          ge     = !diff[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_r <= 1'b0;
      done_r <= 1'b0;
      ovf_r  <= 1'b0;
      rem_r  <= '0;
      q_r    <= '0;
      b_r    <= '0;
      cnt_r  <= '0;
    end else begin
      done_r <= 1'b0;
      if (accept) begin
        if (bad) begin
          q_r    <= '1;
          rem_r  <= '0;
          ovf_r  <= 1'b1;
          done_r <= 1'b1;
        end else begin
          busy_r <= 1'b1;
          rem_r  <= op_a;
          q_r    <= op_c;
          b_r    <= op_b;
          ovf_r  <= 1'b0;
          cnt_r  <= CW'(W);
        end
      end else if (busy_r) begin
        rem_r <= ge ? diff[W-1:0] : trial[W-1:0];
        q_r   <= {q_r[W-2:0], ge};
        cnt_r <= cnt_r - 1'b1;
        if (cnt_r == CW'(1)) begin
          busy_r <= 1'b0;
          done_r <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_r;
  assign done = done_r;
  assign quot = q_r;
  assign rem  = rem_r;
  assign ovf  = ovf_r;
endmodule

// File: rtl/divrem_wide_chk.sv
module divrem_wide_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quot,
  input logic [W-1:0] rem,
  input logic         ovf,
  input logic [W-1:0] b_r
);
  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ovf) |-> (rem < b_r)); // R1
  AST_OVF_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf) |-> ((quot == {W{1'b1}}) && (rem == '0))); // R2
  AST_OVF_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && ((op_b == '0) || (op_a >= op_b))) |=> (done && ovf && !busy)); // R3
  AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (op_b != '0) && (op_a < op_b)) |=> (busy && !done)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(quot) && $stable(rem) && $stable(ovf))); // R6
  AST_BUSY_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(b_r)); // R7
endmodule

bind divrem_wide divrem_wide_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
  .busy(busy), .done(done), .quot(quot), .rem(rem), .ovf(ovf), .b_r(b_r)
);

// File: tb/divrem_wide_bench.sv
module divrem_wide_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0, op_c = '0;
  logic busy, done, ovf;
  logic [W-1:0] quot, rem;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  divrem_wide #(.W(W)) u_divrem_wide (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .busy(busy), .done(done), .quot(quot), .rem(rem), .ovf(ovf)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c,
                        input bit poke, input bit hold);
    logic [2*W-1:0] dvd;
    logic [2*W-1:0] eq, er;
    bit bad;
    int n;
    dvd = {a, c};
    bad = (b == 0) || (a >= b);
    eq = bad ? '0 : dvd / {{W{1'b0}}, b};
    er = bad ? '0 : dvd % {{W{1'b0}}, b};
    op_a = a; op_b = b; op_c = c; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    n = 1;
    if (!bad) check(busy === 1'b1, "R4 busy after start", busy, 1);
    else check(busy === 1'b0, "R3 no busy on overflow", busy, 0);
    if (poke && !bad) begin
      op_a = ~a; op_b = 8'h01; op_c = ~c; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      n++;
    end
    while (done !== 1'b1 && n < 4 * W) begin
      @(posedge clk); #1;
      n++;
    end
    if (bad) begin
      check(n == 1, "R3 overflow latency", n, 1);
      check(quot === {W{1'b1}}, "R2 quot on overflow", quot, {W{1'b1}});
      check(rem === '0, "R2 rem on overflow", rem, 0);
      check(ovf === 1'b1, "R2 ovf flag", ovf, 1);
    end else begin
      check(n == W + 1, "R4 valid latency", n, W + 1);
      check(quot === eq[W-1:0], poke ? "R7 quot after ignored start" : "R1 quot", quot, eq[W-1:0]);
      check(rem === er[W-1:0], poke ? "R7 rem after ignored start" : "R1 rem", rem, er[W-1:0]);
      check(rem < b, "R1 rem below divisor", rem, b);
      check(({{W{1'b0}}, quot} * {{W{1'b0}}, b} + {{W{1'b0}}, rem}) == dvd,
            "R1 reconstruct", {quot, rem}, dvd);
      check(ovf === 1'b0, "R9 ovf clear", ovf, 0);
    end
    check(busy === 1'b0, "R5 busy low with done", busy, 0);
    @(posedge clk); #1;
    check(done === 1'b0, "R5 done one cycle", done, 0);
    if (hold) begin
      repeat (3) @(posedge clk);
      #1;
      check(quot === (bad ? {W{1'b1}} : eq[W-1:0]), "R6 quot held", quot, eq[W-1:0]);
      check(rem === (bad ? {W{1'b0}} : er[W-1:0]), "R6 rem held", rem, er[W-1:0]);
      check(ovf === bad, "R6 ovf held", ovf, bad);
    end
  endtask

  initial begin
    fork
      begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
          checks++; errors++;
          $display("FAIL watchdog actual=timeout expected=finish");
          $display("Simulation finished: %0d checks, %0d errors", checks, errors);
          $finish;
        end
      end
    join_none
    #1;
    check(busy === 1'b0 && done === 1'b0, "R8 reset busy/done", {busy, done}, 0);
    check(ovf === 1'b0 && quot === '0 && rem === '0, "R8 reset outputs", {ovf, quot, rem}, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    check(busy === 1'b0 && done === 1'b0, "R8 idle after reset", {busy, done}, 0);

    run_op(8'hFE, 8'hFF, 8'hFF, 0, 1);
    run_op(8'h00, 8'h01, 8'hA5, 0, 1);
    run_op(8'h05, 8'h00, 8'h11, 0, 1);
    run_op(8'h10, 8'h10, 8'h00, 0, 0);
    run_op(8'h0F, 8'h10, 8'hF0, 0, 0);
    run_op(8'h33, 8'h7B, 8'h9C, 1, 1);
    run_op(8'hC8, 8'hC9, 8'h00, 1, 0);

    for (int b = 0; b < 256; b++) begin
      for (int s = 0; s < 6; s++) begin
        for (int k = 0; k < 3; k++) begin
          logic [W-1:0] a, c;
          case (s)
            0: a = 8'h00;
            1: a = 8'h01;
            2: a = W'(b / 2);
            3: a = W'(b - 1);
            4: a = W'(b);
            default: a = 8'hFF;
          endcase
          case (k)
            0: c = 8'h00;
            1: c = 8'hFF;
            default: c = W'(b * 37 + s * 11 + 90);
          endcase
          run_op(a, W'(b), c, 0, (b % 64) == 3 && k == 0);
        end
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule